// File: doc/BRIEF.md
# Burst Column Engine with Clock Suspend

This block is the column side of a single-data-rate DRAM-style interface. A READ or WRITE command carries a bank and a starting column. The engine then steps through the programmed number of data beats, producing the column address of each beat. Write beats go into a small behavioural storage array. Read beats come back on a registered data output with an output enable.

A clock-enable input provides clock suspend. When a burst is running, or is starting on the same edge, and the enable is sampled low, the following internal edge is skipped. On a skipped edge the engine takes no commands and writes no data. The read output keeps its value and the beat counter stays where it is. When the enable is seen high again, normal stepping resumes on the next edge. If the enable is low while nothing is running, the engine stays idle and does not enter suspend.

Top module: `burst_col_engine`

## Requirements
- R1: While reset is asserted (rst_n low), and on the first edge after it, the output enable is low and no write strobe is raised.
- R2: The burst length select encodes 0→1, 1→2, 2→4 and 3→8 beats and is captured with the command. Beat columns run sequentially from the start column and wrap inside the aligned block of that length.
- R3: The command code is 2'b00 NOP, 2'b01 READ, 2'b10 WRITE, 2'b11 NOP. The first write beat is strobed in the same cycle as the WRITE command. Each later beat is strobed on the next edge that is not suspended.
- R4: A READ makes the first beat's data appear on the output, with the output enable high, one cycle after the command edge. Each later beat appears after its own non-suspended edge.
- R5: An edge that samples clock enable low suspends the next edge, but only while a burst is active or is starting on that same edge.
- R6: On a suspended edge, the command, column and write data are ignored and no write strobe is raised.
- R7: On a suspended edge, the read data output and the output enable keep their values.
- R8: The beat counter does not move on a suspended edge. Stepping resumes on the edge after one that samples clock enable high.
- R9: Clock enable low with no burst active and a NOP command does not suspend the next edge.
- R10: A data mask of 1 on a non-suspended write beat blocks the write strobe for that beat, but the column still advances.
- R11: A READ or WRITE on a non-suspended edge during a burst ends the current burst and starts the new one at the given column.
- R12: The output enable falls on the first non-suspended edge after the final read beat, unless that edge starts a new READ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low requests suspend of the next edge |
| cmd | input | 2 | Command code (NOP, READ, WRITE) |
| cmd_bank | input | BANK_W | Bank of the command |
| cmd_col | input | COL_W | Start column of the command |
| din | input | DATA_W | Write data for the current beat |
| dm | input | 1 | Data mask; 1 blocks the current write beat |
| bl_sel | input | 2 | Burst length select |
| dout | output | DATA_W | Registered read data |
| dout_oe | output | 1 | Read data output enable |
| arr_we | output | 1 | Write strobe into the array for this cycle's beat |
| arr_bank | output | BANK_W | Bank of this cycle's beat |
| arr_col | output | COL_W | Column of this cycle's beat |

## Verification
If the suspend flag is wrong, the effect shows at the ports within one edge. A missed suspend moves the beat column and the read data one beat too early. It can also raise a write strobe in a cycle where the strobe should stay low. A spurious suspend stalls the column and holds stale data for one edge. A wrong beat index or wrong wrap mask shows directly on the beat column in the cycle of that beat. It also shows on the read data one cycle later. The read enable settles only after the last beat, so a wrong end-of-burst test shows as the enable staying high, or falling early, on the edge after the final beat.

// File: rtl/bce_pkg.sv
// Shared types and constants for the burst column engine.
// Assumes a maximum burst of 8 beats.
package bce_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;

    localparam int MAX_BL = 8;
    localparam int IDX_W  = $clog2(MAX_BL) + 1;
endpackage

// File: rtl/bce_suspend_ctl.sv
// Clock-suspend tracker. Assumes in_progress is high while a burst is
// active or starting this edge. A low clock enable sampled then makes
// the next edge a suspended one.
module bce_suspend_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic in_progress,
    output logic suspended,
    output logic edge_en
);
    logic susp_q;

    // Sample the clock enable on every edge; the result governs the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) susp_q <= 1'b0;
        else        susp_q <= ~cke & in_progress;
    end

    assign suspended = susp_q;
    assign edge_en   = ~susp_q;
endmodule

// File: rtl/bce_col_seq.sv
// Column sequencer. Accepts commands on enabled edges, tracks the beat
// index, and derives this cycle's beat address, write strobe and read
// request. Burst length is captured with the command. Assumes COL_W >= 3.
module bce_col_seq #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_en,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              dm,
    input  logic [1:0]        bl_sel,
    output logic              beat_we,
    output logic              beat_rd,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col,
    output logic              active,
    output logic              in_progress,
    output logic [bce_pkg::IDX_W-1:0] beat_idx,
    output logic              rd_oe
);
    import bce_pkg::*;

    logic              active_q, wr_q, oe_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  base_q;
    logic [IDX_W-1:0]  idx_q, beats_q;

    logic              is_col_cmd, start, cont, beat, beat_is_wr, last;
    logic [IDX_W-1:0]  idx, beats;
    logic [COL_W-1:0]  base, mask;

    // Decide whether this edge starts a burst, continues one, or idles.
    always_comb begin
        is_col_cmd = (cmd == CMD_READ) || (cmd == CMD_WRITE);
        start      = edge_en & is_col_cmd;
        cont       = edge_en & active_q & ~is_col_cmd;
        beat       = start | cont;
        beat_is_wr = start ? (cmd == CMD_WRITE) : wr_q;
        base       = start ? cmd_col : base_q;
        beat_bank  = start ? cmd_bank : bank_q;
        idx        = start ? '0 : idx_q;
        beats      = start ? (IDX_W'(1) << bl_sel) : beats_q;
        last       = (idx + IDX_W'(1)) == beats;
    end

    // Sequential wrap inside the aligned block of the burst length.
    always_comb begin
        mask     = COL_W'(beats - IDX_W'(1));
        beat_col = (base & ~mask) | ((base + COL_W'(idx)) & mask);
        beat_we  = beat & beat_is_wr & ~dm;
        beat_rd  = beat & ~beat_is_wr;
    end

    // Burst state advances only on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            bank_q   <= '0;
            base_q   <= '0;
            idx_q    <= '0;
            beats_q  <= IDX_W'(1);
        end else if (edge_en) begin
            if (start) begin
                active_q <= ~last;
                wr_q     <= (cmd == CMD_WRITE);
                bank_q   <= cmd_bank;
                base_q   <= cmd_col;
                idx_q    <= IDX_W'(1);
                beats_q  <= beats;
            end else if (active_q) begin
                active_q <= ~last;
                idx_q    <= idx_q + IDX_W'(1);
            end
        end
    end

    // Output enable follows read beats and holds across suspended edges.
    always_ff @(posedge clk) begin
        if (!rst_n)       oe_q <= 1'b0;
        else if (edge_en) oe_q <= beat_rd;
    end

    assign active      = active_q;
    assign in_progress = active_q | start;
    assign beat_idx    = idx_q;
    assign rd_oe       = oe_q;
endmodule

// File: rtl/bce_array.sv
// Behavioural storage, one array per bank, with a registered read port.
// The read register loads only on read beats, so it holds across
// suspended edges. Storage contents are not reset.
module bce_array #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              rd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int BANKS = 1 << BANK_W;
    localparam int DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] rd_word [BANKS];
    logic [DATA_W-1:0] rdata_q;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        // Store the beat's data when this bank is addressed.
        always_ff @(posedge clk) begin
            if (we && (bank == BANK_W'(b))) mem[col] <= wdata;
        end

        assign rd_word[b] = mem[col];
    end

    // Capture read data for the beat being read.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= rd_word[bank];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/burst_col_engine.sv
// Top of the burst column engine. It ties the suspend tracker, the column
// sequencer and the behavioural array together. Assumes one data-mask
// bit for the whole word and a read latency of one cycle.
module burst_col_engine #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [DATA_W-1:0] din,
    input  logic              dm,
    input  logic [1:0]        bl_sel,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              arr_we,
    output logic [BANK_W-1:0] arr_bank,
    output logic [COL_W-1:0]  arr_col
);
    logic suspended, edge_en, in_progress, burst_active, beat_rd;
    logic [bce_pkg::IDX_W-1:0] beat_idx;

    bce_suspend_ctl u_susp (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke         (cke),
        .in_progress (in_progress),
        .suspended   (suspended),
        .edge_en     (edge_en)
    );

    bce_col_seq #(.BANK_W(BANK_W), .COL_W(COL_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_en     (edge_en),
        .cmd         (cmd),
        .cmd_bank    (cmd_bank),
        .cmd_col     (cmd_col),
        .dm          (dm),
        .bl_sel      (bl_sel),
        .beat_we     (arr_we),
        .beat_rd     (beat_rd),
        .beat_bank   (arr_bank),
        .beat_col    (arr_col),
        .active      (burst_active),
        .in_progress (in_progress),
        .beat_idx    (beat_idx),
        .rd_oe       (dout_oe)
    );

    bce_array #(.BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .rd    (beat_rd),
        .bank  (arr_bank),
        .col   (arr_col),
        .wdata (din),
        .rdata (dout)
    );
endmodule

// File: rtl/bce_checker.sv
// Property checker for the burst column engine, bound to the top module.
module bce_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic [1:0]        cmd,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic              arr_we,
    input logic              suspended,
    input logic              burst_active,
    input logic [bce_pkg::IDX_W-1:0] beat_idx
);
    assert_enter_suspend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && burst_active) |=> suspended);

    assert_idle_no_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !burst_active && cmd == 2'b00) |=> !suspended);

    assert_no_strobe_suspended_R6: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> !arr_we);

    assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |=> ($stable(dout) && $stable(dout_oe)));

    assert_counter_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |=> ($stable(beat_idx) && $stable(burst_active)));

    assert_read_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspended && cmd == 2'b01) |=> dout_oe);

    assert_oe_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspended && !burst_active && cmd != 2'b01) |=> !dout_oe);
endmodule

bind burst_col_engine bce_checker #(.DATA_W(DATA_W)) u_bce_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke          (cke),
    .cmd          (cmd),
    .dout         (dout),
    .dout_oe      (dout_oe),
    .arr_we       (arr_we),
    .suspended    (suspended),
    .burst_active (burst_active),
    .beat_idx     (beat_idx)
);

// File: tb/burst_col_engine_bench.sv
module burst_col_engine_bench;
    localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic [1:0]  cmd = NOP;
    logic [1:0]  cmd_bank = '0;
    logic [5:0]  cmd_col = '0;
    logic [15:0] din = '0;
    logic        dm = 1'b0;
    logic [1:0]  bl_sel = 2'd2;
    logic [15:0] dout;
    logic        dout_oe, arr_we;
    logic [1:0]  arr_bank;
    logic [5:0]  arr_col;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    burst_col_engine u_burst_col_engine (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .din(din), .dm(dm), .bl_sel(bl_sel), .dout(dout),
        .dout_oe(dout_oe), .arr_we(arr_we), .arr_bank(arr_bank), .arr_col(arr_col)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic        cke;
        logic [1:0]  cmd;
        logic [5:0]  col;
        logic [15:0] din;
        logic        dm;
        logic        we;
        logic        chk_col;
        logic [5:0]  col_x;
        logic        oe;
        logic        chk_d;
        logic [15:0] d_x;
    } vec_t;

    // Bank 1, burst of 4: write 5,6,7,4 with one suspended edge, then read 6,7,4,5.
    localparam vec_t VECS [12] = '{
        '{1'b1, WR,  6'd5, 16'hA0A0, 1'b0, 1'b1, 1'b1, 6'd5, 1'b0, 1'b0, 16'h0},
        '{1'b1, NOP, 6'd0, 16'hA1A1, 1'b0, 1'b1, 1'b1, 6'd6, 1'b0, 1'b0, 16'h0},
        '{1'b0, NOP, 6'd0, 16'hA2A2, 1'b0, 1'b1, 1'b1, 6'd7, 1'b0, 1'b0, 16'h0},
        '{1'b1, WR,  6'd0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 16'h0},
        '{1'b1, NOP, 6'd0, 16'hA3A3, 1'b0, 1'b1, 1'b1, 6'd4, 1'b0, 1'b0, 16'h0},
        '{1'b1, RD,  6'd6, 16'h0000, 1'b0, 1'b0, 1'b1, 6'd6, 1'b1, 1'b1, 16'hA1A1},
        '{1'b0, NOP, 6'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 6'd7, 1'b1, 1'b1, 16'hA2A2},
        '{1'b0, NOP, 6'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 16'hA2A2},
        '{1'b1, NOP, 6'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 16'hA2A2},
        '{1'b1, NOP, 6'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 6'd4, 1'b1, 1'b1, 16'hA3A3},
        '{1'b1, NOP, 6'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 6'd5, 1'b1, 1'b1, 16'hA0A0},
        '{1'b1, NOP, 6'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 16'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge; combinational outputs settle 1 ns later.
    task automatic drive(input logic c, input logic [1:0] op, input logic [1:0] b,
                         input logic [5:0] col, input logic [15:0] d, input logic m);
        @(negedge clk);
        cke = c; cmd = op; cmd_bank = b; cmd_col = col; din = d; dm = m;
        #1;
    endtask

    task automatic edge_pass();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) edge_pass();
        check("R1 oe in reset", dout_oe, 0);
        check("R1 we in reset", arr_we, 0);
        @(negedge clk); rst_n = 1'b1;
        edge_pass();
        check("R1 oe after reset", dout_oe, 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R12
        bl_sel = 2'd2;
        foreach (VECS[i]) begin
            drive(VECS[i].cke, VECS[i].cmd, 2'd1, VECS[i].col, VECS[i].din, VECS[i].dm);
            check($sformatf("R3/R6 we vec%0d", i), arr_we, VECS[i].we);
            if (VECS[i].chk_col) check($sformatf("R2/R8 col vec%0d", i), arr_col, VECS[i].col_x);
            edge_pass();
            check($sformatf("R4/R7/R12 oe vec%0d", i), dout_oe, VECS[i].oe);
            if (VECS[i].chk_d) check($sformatf("R4/R7 dout vec%0d", i), dout, VECS[i].d_x);
        end

        // R11: truncate a burst of 8 with a new WRITE
        bl_sel = 2'd3;
        drive(1, WR, 2'd2, 6'd10, 16'h0101, 0); check("R11 first col", arr_col, 10); edge_pass();
        drive(1, NOP, 2'd2, 6'd0, 16'h0202, 0); check("R11 second col", arr_col, 11); edge_pass();
        drive(1, WR, 2'd2, 6'd20, 16'h0303, 0); check("R11 new start col", arr_col, 20);
        check("R11 new start we", arr_we, 1); edge_pass();
        drive(1, NOP, 2'd2, 6'd0, 16'h0404, 0); check("R11 continues from new col", arr_col, 21); edge_pass();

        // R2 wrap at length 2 and R10 data mask
        bl_sel = 2'd1;
        drive(1, WR, 2'd3, 6'd2, 16'h3333, 0); edge_pass();
        drive(1, NOP, 2'd3, 6'd0, 16'h4444, 0); check("R2 len2 second col", arr_col, 3); edge_pass();
        drive(1, WR, 2'd3, 6'd3, 16'h5555, 0); edge_pass();
        drive(1, NOP, 2'd3, 6'd0, 16'h6666, 1);
        check("R10 masked no strobe", arr_we, 0);
        check("R2 R10 wrapped col advances", arr_col, 2); edge_pass();
        drive(1, RD, 2'd3, 6'd2, 16'h0, 0); edge_pass();
        check("R10 masked col kept data", dout, 16'h3333);
        drive(1, NOP, 2'd3, 6'd0, 16'h0, 0); edge_pass();
        check("R2 R4 second read beat", dout, 16'h5555);
        drive(1, NOP, 2'd3, 6'd0, 16'h0, 0); edge_pass();
        check("R12 oe falls after last", dout_oe, 0);

        // R2 length 1 read
        bl_sel = 2'd0;
        drive(1, RD, 2'd1, 6'd5, 16'h0, 0); edge_pass();
        check("R2 R4 len1 data", dout, 16'hA0A0);
        drive(1, NOP, 2'd1, 6'd0, 16'h0, 0); edge_pass();
        check("R12 len1 oe low", dout_oe, 0);

        // R9: clock enable low while idle does not suspend
        drive(0, NOP, 2'd0, 6'd0, 16'h0, 0); edge_pass();
        drive(1, WR, 2'd0, 6'd1, 16'h7777, 0);
        check("R9 command accepted after idle low cke", arr_we, 1); edge_pass();

        // R5/R7/R6: suspend requested on the starting edge holds the final read beat
        drive(0, RD, 2'd0, 6'd1, 16'h0, 0); edge_pass();
        check("R4 read data", dout, 16'h7777);
        drive(1, WR, 2'd0, 6'd1, 16'h8888, 0);
        check("R5 R6 suspended edge blocks write", arr_we, 0); edge_pass();
        check("R7 oe held by suspend", dout_oe, 1);
        check("R7 data held by suspend", dout, 16'h7777);
        drive(1, NOP, 2'd0, 6'd0, 16'h0, 0); edge_pass();
        check("R12 oe low after resume", dout_oe, 0);
        drive(1, RD, 2'd0, 6'd1, 16'h0, 0); edge_pass();
        check("R6 ignored write left data", dout, 16'h7777);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule